// File: doc/BRIEF.md
# BCH(63,51) Syndrome and Error-Locator Solver

This block is the front half of a double-error-correcting binary BCH decoder for 63-bit words. It takes a received word and computes the two odd syndromes over GF(64). From them it derives the three coefficients of the degree-2 error-locator polynomial. No field inversion is used anywhere. Root search and bit correction sit in a later stage and use the coefficients this block reports.

A word enters in one of two ways. The first is as a parallel load of all 63 bits, which the block then walks through internally, one bit per cycle. The second is as a serial stream with a qualifier, highest-order bit first, where idle gaps between bits are allowed. Each syndrome is built by Horner's rule with a constant multiplier. A single general GF(64) multiplier then forms S1 squared and S1 cubed over two further cycles. In the next cycle the locator coefficients and the two flags are loaded, and a one-cycle done pulse is given with them.

Top module: `bch63_locator_solver`

## Requirements
- R1: Field elements are 6-bit values in polynomial basis, where bit k is the coefficient of a^k, and products are reduced modulo x^6 + x + 1. For example, an error at position 6 gives lam0 = 6'h03, and an error at position 62 gives lam0 = 6'h21.
- R2: Word bit 62 is the highest-order coefficient and is the first bit processed. A set bit at position j adds a^j to S1 and a^(3j) to S3.
- R3: When done is high, lam0 = S1, lam1 = S1^2 and lam2 = S3 + S1^3.
- R4: err_det is high exactly when S1 or S3 is nonzero. Any multiple of x^12+x^10+x^8+x^5+x^4+x^3+1 (a codeword) gives err_det = 0 and all coefficients zero, and adding a codeword to a word does not change any output.
- R5: A word with a single set error bit at position j gives lam0 = a^j, lam1 = a^(2j), lam2 = 0, err_det = 1 and uncorr = 0.
- R6: uncorr is high exactly when S1 = 0 and S3 is nonzero.
- R7: After a parallel load is accepted at clock edge L, done is high only in the cycle that follows edge L+66, for exactly one cycle.
- R8: In serial mode, a bit is taken only on a cycle with bit_valid high, and gaps are allowed. Done rises at the third edge after the edge that takes the 63rd bit.
- R9: While a word is being processed, both load and bit_valid are ignored. The result and its timing belong to the word already accepted.
- R10: Reset clears all outputs to zero. Between done pulses the coefficient and flag outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Parallel load strobe, taken only when idle |
| word_i | input | 63 | Received word for a parallel load, bit 62 highest order |
| bit_valid_i | input | 1 | Serial bit qualifier |
| bit_i | input | 1 | Serial received bit, highest order first |
| lam0_o | output | 6 | Locator coefficient lambda0 (S1) |
| lam1_o | output | 6 | Locator coefficient lambda1 (S1 squared) |
| lam2_o | output | 6 | Locator coefficient lambda2 (S3 + S1 cubed) |
| err_det_o | output | 1 | Nonzero syndrome seen |
| uncorr_o | output | 1 | S1 zero while S3 nonzero |
| done_o | output | 1 | One-cycle pulse when the outputs above are updated |

## Verification
The bench builds the block with its default parameters: a 6-bit field with reduction polynomial x^6+x+1 and a 63-bit word. These defaults bring the boundary positions 0 and 62 within reach, along with reduction wrap-around on the constant multipliers and the exact 66-cycle load-to-done latency. Expected values come from a logarithm/antilog model of GF(64). Codewords are built as multiples of the generator polynomial, so the bench can show that only the error pattern matters. Serial runs with idle gaps are compared against parallel loads of the same word.

// File: rtl/bch_loc_pkg.sv
// Package: shared constants and the controller state type for the
// BCH(63,51) syndrome / locator solver. Assumes a binary code with t = 2.
package bch_loc_pkg;
    localparam int          GF_M     = 6;
    localparam int          CODE_N   = 63;
    // Low M bits of the primitive polynomial x^6 + x + 1
    localparam logic [5:0]  GF_POLY  = 6'b000011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_SQ,
        ST_CUBE,
        ST_OUT
    } loc_state_t;
endpackage

// File: rtl/gf_poly_mul.sv
// Module: combinational GF(2^M) multiplier in polynomial basis.
// Starts from the most significant bit of b_i. The partial result is
// multiplied by alpha (shift plus conditional reduction) and a_i is
// added whenever the current bit of b_i is set. Uses AND/XOR only.
// Assumes POLY_LO holds the primitive polynomial without its x^M term.
module gf_poly_mul #(
    parameter int             M       = 6,
    parameter logic [M-1:0]   POLY_LO = 6'b000011
) (
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    output logic [M-1:0] p_o
);
    logic [M-1:0] acc;

    // Horner-style product, most significant element first
    always_comb begin
        acc = '0;
        for (int i = M - 1; i >= 0; i--) begin
            acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY_LO : '0);
            if (b_i[i]) acc = acc ^ a_i;
        end
    end

    assign p_o = acc;

    // Check multiplication by one is identity
    always_comb begin
        // R1
        if (b_i == {{(M-1){1'b0}}, 1'b1}) begin
            mul_unit_chk: assert (p_o == a_i);
        end
    end
endmodule

// File: rtl/horner_acc.sv
// Module: one syndrome accumulator. On each taken bit it computes
// S <- S * alpha^POW + bit. When first_i is set, the old value is
// treated as zero. The constant multiply is POW repeated
// multiply-by-alpha steps.
// Assumes bits arrive highest order first.
module horner_acc #(
    parameter int             M       = 6,
    parameter logic [M-1:0]   POLY_LO = 6'b000011,
    parameter int             POW     = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_i,
    input  logic         first_i,
    input  logic         bit_i,
    output logic [M-1:0] syn_o
);
    logic [M-1:0] syn_q;
    logic [M-1:0] nxt;

    // Next accumulator value: constant multiply by alpha^POW, then add bit
    always_comb begin
        nxt = first_i ? '0 : syn_q;
        for (int k = 0; k < POW; k++) begin
            nxt = {nxt[M-2:0], 1'b0} ^ (nxt[M-1] ? POLY_LO : '0);
        end
        nxt = nxt ^ {{(M-1){1'b0}}, bit_i};
    end

    // Accumulator register, updated only on taken bits
    always_ff @(posedge clk) begin
        if (!rst_n)      syn_q <= '0;
        else if (take_i) syn_q <= nxt;
    end

    assign syn_o = syn_q;

    // R2
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && first_i) |=> (syn_q == {{(M-1){1'b0}}, $past(bit_i)}));
endmodule

// File: rtl/locator_ctrl.sv
// Module: sequencer for the solver. It takes a parallel word (and
// shifts it out internally) or serial qualified bits, counts N bits, and
// then steps through the square, cube and output-load states.
// Assumes load has priority over a serial bit when both arrive in idle.
module locator_ctrl
    import bch_loc_pkg::*;
#(
    parameter int N  = 63,
    parameter int CW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] word_i,
    input  logic         bit_valid_i,
    input  logic         bit_i,
    output logic         take_o,
    output logic         first_o,
    output logic         bit_o,
    output loc_state_t   state_o
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    loc_state_t    state_q;
    logic [N-1:0]  shreg_q;
    logic          par_q;
    logic [CW-1:0] cnt_q;
    logic          last_take;

    // Bit acceptance: serial bits only when idle or shifting a serial word
    always_comb begin
        take_o = 1'b0;
        if (state_q == ST_IDLE)       take_o = !load_i && bit_valid_i;
        else if (state_q == ST_SHIFT) take_o = par_q || bit_valid_i;
    end

    assign bit_o     = (state_q == ST_SHIFT && par_q) ? shreg_q[N-1] : bit_i;
    assign first_o   = (cnt_q == '0);
    assign last_take = take_o && (cnt_q == LAST);
    assign state_o   = state_q;

    // State, bit counter and parallel shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            par_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (take_o) cnt_q <= last_take ? '0 : cnt_q + 1'b1;
            if (take_o && par_q) shreg_q <= {shreg_q[N-2:0], 1'b0};
            unique case (state_q)
                ST_IDLE: begin
                    if (load_i) begin
                        shreg_q <= word_i;
                        par_q   <= 1'b1;
                        state_q <= ST_SHIFT;
                    end else if (bit_valid_i) begin
                        par_q   <= 1'b0;
                        state_q <= last_take ? ST_SQ : ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (last_take) begin
                        par_q   <= 1'b0;
                        state_q <= ST_SQ;
                    end
                end
                ST_SQ:   state_q <= ST_CUBE;
                ST_CUBE: state_q <= ST_OUT;
                ST_OUT:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_take |=> (state_q == ST_SQ));
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R9
    busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQ || state_q == ST_CUBE || state_q == ST_OUT) |-> !take_o);
endmodule

// File: rtl/bch63_locator_solver.sv
// Module: top of the BCH(63,51) syndrome and inversionless locator solver.
// Two Horner accumulators form S1 and S3 while bits are taken. One
// general GF(64) multiplier then forms S1^2 and S1^3 in two cycles. The
// outputs load in the third cycle with a done pulse.
// Assumes binary t = 2: lam0 = S1, lam1 = S1^2, lam2 = S3 + S1^3.
module bch63_locator_solver
    import bch_loc_pkg::*;
#(
    parameter int           M       = GF_M,
    parameter int           N       = CODE_N,
    parameter logic [M-1:0] POLY_LO = GF_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] word_i,
    input  logic         bit_valid_i,
    input  logic         bit_i,
    output logic [M-1:0] lam0_o,
    output logic [M-1:0] lam1_o,
    output logic [M-1:0] lam2_o,
    output logic         err_det_o,
    output logic         uncorr_o,
    output logic         done_o
);
    localparam int NSYN = 2;

    loc_state_t   state;
    logic         take, first, sbit;
    logic [M-1:0] syn [NSYN];
    logic [M-1:0] mul_a, prod;
    logic [M-1:0] sq_q, cube_q;

    locator_ctrl #(.N(N)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .word_i      (word_i),
        .bit_valid_i (bit_valid_i),
        .bit_i       (bit_i),
        .take_o      (take),
        .first_o     (first),
        .bit_o       (sbit),
        .state_o     (state)
    );

    // Odd syndromes S1 (alpha^1) and S3 (alpha^3)
    for (genvar g = 0; g < NSYN; g++) begin : g_syn
        horner_acc #(.M(M), .POLY_LO(POLY_LO), .POW(2 * g + 1)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .take_i  (take),
            .first_i (first),
            .bit_i   (sbit),
            .syn_o   (syn[g])
        );
    end

    // Shared multiplier: S1*S1 in ST_SQ, S1^2*S1 in ST_CUBE
    assign mul_a = (state == ST_CUBE) ? sq_q : syn[0];

    gf_poly_mul #(.M(M), .POLY_LO(POLY_LO)) u_mul (
        .a_i (mul_a),
        .b_i (syn[0]),
        .p_o (prod)
    );

    // Power registers, result registers and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q      <= '0;
            cube_q    <= '0;
            lam0_o    <= '0;
            lam1_o    <= '0;
            lam2_o    <= '0;
            err_det_o <= 1'b0;
            uncorr_o  <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= (state == ST_OUT);
            if (state == ST_SQ)   sq_q   <= prod;
            if (state == ST_CUBE) cube_q <= prod;
            if (state == ST_OUT) begin
                lam0_o    <= syn[0];
                lam1_o    <= sq_q;
                lam2_o    <= syn[1] ^ cube_q;
                err_det_o <= (syn[0] != '0) || (syn[1] != '0);
                uncorr_o  <= (syn[0] == '0) && (syn[1] != '0);
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({lam0_o, lam1_o, lam2_o, err_det_o, uncorr_o}) |-> done_o);
    // R6
    uncorr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_o |-> (err_det_o && lam0_o == '0 && lam1_o == '0));
    // R3
    square_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lam0_o == '0) |-> (lam1_o == '0 && lam2_o == $past(syn[1])));
endmodule

// File: tb/bch63_locator_solver_test.sv
`timescale 1ns/1ps
module bch63_locator_solver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [62:0] word = '0;
    logic        bv = 1'b0;
    logic        bi = 1'b0;
    logic [5:0]  lam0, lam1, lam2;
    logic        err_det, uncorr, done;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_t [0:62];
    int         log_t [0:63];
    localparam logic [62:0] GEN = 63'h1539;

    bch63_locator_solver uut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .word_i(word),
        .bit_valid_i(bv), .bit_i(bi),
        .lam0_o(lam0), .lam1_o(lam1), .lam2_o(lam2),
        .err_det_o(err_det), .uncorr_o(uncorr), .done_o(done));

    always #2.5 clk = ~clk;

    function automatic logic [5:0] gmul(logic [5:0] a, logic [5:0] b);
        if (a == 0 || b == 0) return 6'h0;
        return exp_t[(log_t[a] + log_t[b]) % 63];
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic expect_word(string tag, logic [62:0] w);
        logic [5:0] s1, s3, s1c;
        s1 = 0; s3 = 0;
        for (int j = 0; j < 63; j++) begin
            if (w[j]) begin
                s1 = s1 ^ exp_t[j];
                s3 = s3 ^ exp_t[(3 * j) % 63];
            end
        end
        s1c = gmul(gmul(s1, s1), s1);
        chk({tag, " R3 lam0"}, {2'b0, lam0}, {2'b0, s1});
        chk({tag, " R3 lam1"}, {2'b0, lam1}, {2'b0, gmul(s1, s1)});
        chk({tag, " R3 lam2"}, {2'b0, lam2}, {2'b0, s3 ^ s1c});
        chk({tag, " R4 err_det"}, {7'b0, err_det}, {7'b0, (s1 != 0) || (s3 != 0)});
        chk({tag, " R6 uncorr"}, {7'b0, uncorr}, {7'b0, (s1 == 0) && (s3 != 0)});
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (done !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (n >= 300) chk({tag, " R7 done timeout"}, 8'h0, 8'h1);
    endtask

    task automatic run_par(logic [62:0] w);
        @(negedge clk);
        load = 1'b1; word = w;
        @(negedge clk);
        load = 1'b0;
        wait_done("par");
    endtask

    task automatic t_reset;
        chk("R10 reset done", {7'b0, done}, 8'h0);
        chk("R10 reset lam0", {2'b0, lam0}, 8'h0);
        chk("R10 reset lam2", {2'b0, lam2}, 8'h0);
        chk("R10 reset err_det", {7'b0, err_det}, 8'h0);
        chk("R10 reset uncorr", {7'b0, uncorr}, 8'h0);
    endtask

    task automatic t_codeword;
        logic [62:0] c;
        run_par('0);
        expect_word("R4 zero word", '0);
        c = GEN ^ (GEN << 7) ^ (GEN << 50);
        run_par(c);
        chk("R4 codeword err_det", {7'b0, err_det}, 8'h0);
        chk("R4 codeword lam0", {2'b0, lam0}, 8'h0);
        chk("R4 codeword lam2", {2'b0, lam2}, 8'h0);
    endtask

    task automatic t_single;
        run_par(63'h1 << 6);
        chk("R1 reduce pos6 lam0", {2'b0, lam0}, 8'h03);
        run_par(63'h1 << 62);
        chk("R1 pos62 lam0", {2'b0, lam0}, 8'h21);
        expect_word("R2 pos62", 63'h1 << 62);
        foreach (exp_t[j]) begin
            if (j == 0 || j == 17 || j == 40) begin
                run_par(63'h1 << j);
                chk("R5 single lam0", {2'b0, lam0}, {2'b0, exp_t[j]});
                chk("R5 single lam1", {2'b0, lam1}, {2'b0, exp_t[(2 * j) % 63]});
                chk("R5 single lam2", {2'b0, lam2}, 8'h0);
                chk("R5 single err_det", {7'b0, err_det}, 8'h1);
                chk("R5 single uncorr", {7'b0, uncorr}, 8'h0);
            end
        end
    endtask

    task automatic t_double;
        logic [62:0] e, c;
        logic [5:0]  r0, r1, r2;
        e = (63'h1 << 3) | (63'h1 << 55);
        run_par(e);
        expect_word("R3 double", e);
        chk("R3 double lam2 nonzero", {7'b0, lam2 != 0}, 8'h1);
        r0 = lam0; r1 = lam1; r2 = lam2;
        c = (GEN << 2) ^ (GEN << 33) ^ (GEN << 49);
        run_par(c ^ e);
        chk("R4 pattern-only lam0", {2'b0, lam0}, {2'b0, r0});
        chk("R4 pattern-only lam1", {2'b0, lam1}, {2'b0, r1});
        chk("R4 pattern-only lam2", {2'b0, lam2}, {2'b0, r2});
    endtask

    task automatic t_uncorr;
        logic [62:0] w;
        w = 63'h43;  // x^6 + x + 1 : S1 = 0
        run_par(w);
        expect_word("R6 s1 zero", w);
        chk("R6 uncorr set", {7'b0, uncorr}, 8'h1);
    endtask

    task automatic t_latency;
        @(negedge clk);
        load = 1'b1; word = 63'h1 << 20;
        @(negedge clk);
        load = 1'b0;
        for (int k = 1; k <= 67; k++) begin
            @(negedge clk);
            if (k == 65) chk("R7 done before", {7'b0, done}, 8'h0);
            if (k == 66) chk("R7 done at 66", {7'b0, done}, 8'h1);
            if (k == 67) chk("R7 done one cycle", {7'b0, done}, 8'h0);
        end
    endtask

    task automatic t_serial;
        logic [62:0] w;
        w = (63'h1 << 9) | (63'h1 << 44) | GEN;
        for (int j = 62; j >= 0; j--) begin
            if (j % 5 == 0) begin
                bv = 1'b0; bi = 1'b1;
                @(negedge clk);
            end
            bv = 1'b1; bi = w[j];
            @(negedge clk);
        end
        bv = 1'b0; bi = 1'b0;
        @(negedge clk);
        chk("R8 serial done +1", {7'b0, done}, 8'h0);
        @(negedge clk);
        chk("R8 serial done +2", {7'b0, done}, 8'h0);
        @(negedge clk);
        chk("R8 serial done +3", {7'b0, done}, 8'h1);
        expect_word("R8 serial gaps", w);
    endtask

    task automatic t_busy;
        logic [62:0] a;
        a = (63'h1 << 11) | (63'h1 << 30);
        @(negedge clk);
        load = 1'b1; word = a;
        @(negedge clk);
        load = 1'b0;
        for (int k = 1; k <= 66; k++) begin
            if (k == 10 || k == 64) begin
                load = 1'b1; word = 63'h1 << 5; bv = 1'b1; bi = 1'b1;
            end else begin
                load = 1'b0; bv = 1'b0; bi = 1'b0;
            end
            @(negedge clk);
        end
        load = 1'b0; bv = 1'b0;
        chk("R9 busy timing", {7'b0, done}, 8'h1);
        expect_word("R9 busy ignored", a);
    endtask

    task automatic t_hold;
        logic [5:0] h0, h2;
        logic       he;
        h0 = lam0; h2 = lam2; he = err_det;
        repeat (20) @(negedge clk);
        chk("R10 hold lam0", {2'b0, lam0}, {2'b0, h0});
        chk("R10 hold lam2", {2'b0, lam2}, {2'b0, h2});
        chk("R10 hold err_det", {7'b0, err_det}, {7'b0, he});
    endtask

    initial begin
        logic [6:0] v;
        v = 7'h1;
        for (int i = 0; i < 63; i++) begin
            exp_t[i] = v[5:0];
            log_t[v[5:0]] = i;
            v = {v[5:0], 1'b0};
            if (v[6]) v = v ^ 7'h43;
        end
        log_t[0] = 0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_codeword();
        t_single();
        t_double();
        t_uncorr();
        t_latency();
        t_serial();
        t_busy();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog R7 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule